// File: doc/BRIEF.md
# Hotplug and Receiver-Sense Change Detector

This block watches six level signals coming from a display transmitter PHY: the hotplug-detect line, four per-lane receiver-sense lines and the PHY lock flag. Each is brought into the local clock domain through a synchroniser. Their current values are readable in a live status register. Software programs a polarity register that names the level each input should be waited for. When a synchronised input becomes equal to its polarity bit and that input is not masked, a sticky event bit is set. Event bits feed a single interrupt line through a per-bit mute register.

A typical driver sets the hotplug polarity to high and waits for the interrupt, which signals a connect. It then clears the event and sets the polarity to low so that the next interrupt signals a disconnect. The live register and the event register order the same signals differently. The live layout is used by the polarity and mask registers. The event layout is used by the mute register.

Top module: `hpd_sense_monitor`

## Requirements
- R1: After reset, registers read as follows: live 0x00 (with all inputs low), polarity 0x00, mask 0xF3, events 0x00, mute 0x3F, and `irqOut` is low.
- R2: Live status (address 0) has PHY lock at bit 0, hotplug at bit 1 and receiver sense 0..3 at bits 4..7. Bits 2 and 3 read 0. A raw input change appears in this register after exactly two rising clock edges.
- R3: An event bit is set on the third rising edge after a raw input changes to the level given by its polarity bit. It is set only once while the input stays at that level.
- R4: The event register (address 3) has hotplug at bit 0, PHY lock at bit 1 and receiver sense 0..3 at bits 2..5. Bits 6 and 7 read 0.
- R5: In the mask register (address 2, live layout), a 1 blocks that input's event. An input that reaches its polarity level while masked sets nothing. Unmasking an input that already matches its polarity also sets nothing.
- R6: Writing a polarity bit (address 1, live layout, 1 = wait for high) so that it already equals the current input level sets that event bit exactly once.
- R7: In the event register, writing 1 to a bit clears it and writing 0 leaves it unchanged. If a clear and a new event for the same bit fall on the same edge, the bit stays set.
- R8: `irqOut` is high exactly when some event bit is set and its mute bit (address 4, event layout, 1 = suppress) is 0. Muting does not change the event register.
- R9: Writes to address 0 are ignored. Addresses 5..7 read 0. Reserved bits of the polarity, mask and mute registers cannot be written and read 0.
- R10: With hotplug polarity 1, a rising hotplug sets event bit 0 (connect). After the event is cleared and the polarity is set to 0, a falling hotplug sets it again (disconnect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the addressed register (combinational) |
| hotplugRaw | input | 1 | Asynchronous hotplug-detect level |
| phyLockRaw | input | 1 | Asynchronous PHY lock level |
| rxSenseRaw | input | 4 | Asynchronous receiver-sense levels, one per lane |
| irqOut | output | 1 | Interrupt request |

## Verification
A wrong previous-match flag shows up at the ports within one cycle of the next polarity write or input change. It appears either as an event that should not exist or as a transition that is missed. A wrong mapping between the live and event layouts is exposed the first time a single lane is toggled on its own, because the event appears at the wrong bit position. A synchroniser with the wrong depth shifts both the live register and the event by one edge, so the checks sample on the exact edges where the value must still be old or must already be new. Mute and clear faults appear on `irqOut` and on the event register in the cycle right after the write.

// File: rtl/hpdmon_pkg.sv
package hpdmon_pkg;

  // Register offsets on the byte bus
  localparam int ADR_LIVE  = 0;
  localparam int ADR_POL   = 1;
  localparam int ADR_MASK  = 2;
  localparam int ADR_EVENT = 3;
  localparam int ADR_MUTE  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPol;
    logic wrMask;
    logic wrMute;
    logic clrEvent;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_LIVE  = 3'd1,
    SEL_POL   = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_EVENT = 3'd4,
    SEL_MUTE  = 3'd5
  } rdSel_e;

endpackage

// File: rtl/hpdmon_sync.sv
module hpdmon_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/hpdmon_ctrl.sv
module hpdmon_ctrl
  import hpdmon_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe,
  output rdSel_e            rdSel
);

  always_comb begin
    strobe = '0;
    rdSel  = SEL_NONE;
    case (regAddr)
      ADDR_W'(ADR_LIVE):  rdSel = SEL_LIVE;
      ADDR_W'(ADR_POL): begin
        rdSel        = SEL_POL;
        strobe.wrPol = regWrEn;
      end
      ADDR_W'(ADR_MASK): begin
        rdSel         = SEL_MASK;
        strobe.wrMask = regWrEn;
      end
      ADDR_W'(ADR_EVENT): begin
        rdSel           = SEL_EVENT;
        strobe.clrEvent = regWrEn;
      end
      ADDR_W'(ADR_MUTE): begin
        rdSel         = SEL_MUTE;
        strobe.wrMute = regWrEn;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hpdmon_datapath.sv
module hpdmon_datapath
  import hpdmon_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BUS_W  = 8,
  localparam int LIVE_W = 4 + LANES,
  localparam int INT_W  = 2 + LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  rdSel_e            rdSel,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [LIVE_W-1:0] liveIn,
  output logic [BUS_W-1:0]  rdData,
  output logic              irq,
  output logic [LIVE_W-1:0] polarityReg,
  output logic [LIVE_W-1:0] maskReg,
  output logic [INT_W-1:0]  intStatus,
  output logic [INT_W-1:0]  muteReg
);

  // Bits of the live layout that carry a signal
  localparam logic [LIVE_W-1:0] LIVE_USED = {{LANES{1'b1}}, 2'b00, 2'b11};

  logic [INT_W-1:0] liveI, polI, maskI;
  logic [INT_W-1:0] matchNow, matchPrev, newEvent, clrBits;

  // Re-order live layout into event layout
  assign liveI[0] = liveIn[1];
  assign liveI[1] = liveIn[0];
  assign polI[0]  = polarityReg[1];
  assign polI[1]  = polarityReg[0];
  assign maskI[0] = maskReg[1];
  assign maskI[1] = maskReg[0];
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign liveI[2+i] = liveIn[4+i];
    assign polI[2+i]  = polarityReg[4+i];
    assign maskI[2+i] = maskReg[4+i];
  end

  assign matchNow = ~(liveI ^ polI);
  assign newEvent = matchNow & ~matchPrev & ~maskI;
  assign clrBits  = strobe.clrEvent ? wrData[INT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polarityReg <= '0;
      maskReg     <= LIVE_USED;
      muteReg     <= '1;
      intStatus   <= '0;
      matchPrev   <= '1;
    end else begin
      matchPrev <= matchNow;
      intStatus <= (intStatus & ~clrBits) | newEvent;
      if (strobe.wrPol)  polarityReg <= wrData[LIVE_W-1:0] & LIVE_USED;
      if (strobe.wrMask) maskReg     <= wrData[LIVE_W-1:0] & LIVE_USED;
      if (strobe.wrMute) muteReg     <= wrData[INT_W-1:0];
    end
  end

  assign irq = |(intStatus & ~muteReg);

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_LIVE:  rdData = BUS_W'(liveIn);
      SEL_POL:   rdData = BUS_W'(polarityReg);
      SEL_MASK:  rdData = BUS_W'(maskReg);
      SEL_EVENT: rdData = BUS_W'(intStatus);
      SEL_MUTE:  rdData = BUS_W'(muteReg);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/hpd_sense_monitor.sv
module hpd_sense_monitor
  import hpdmon_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int ADDR_W      = 3,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LIVE_W = 4 + LANES,
  localparam int INT_W  = 2 + LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic              hotplugRaw,
  input  logic              phyLockRaw,
  input  logic [LANES-1:0]  rxSenseRaw,
  output logic              irqOut
);

  strobe_t           strobe;
  rdSel_e            rdSel;
  logic [INT_W-1:0]  syncOut;
  logic [LIVE_W-1:0] liveStatus, polarityReg, maskReg;
  logic [INT_W-1:0]  intStatus, muteReg;

  hpdmon_sync #(.WIDTH(INT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({rxSenseRaw, hotplugRaw, phyLockRaw}),
    .dout(syncOut)
  );

  assign liveStatus = {syncOut[INT_W-1:2], 2'b00, syncOut[1:0]};

  hpdmon_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  hpdmon_datapath #(.LANES(LANES), .BUS_W(BUS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdSel      (rdSel),
    .wrData     (regWrData),
    .liveIn     (liveStatus),
    .rdData     (regRdData),
    .irq        (irqOut),
    .polarityReg(polarityReg),
    .maskReg    (maskReg),
    .intStatus  (intStatus),
    .muteReg    (muteReg)
  );

endmodule

// File: rtl/hpd_sense_monitor_chk.sv
module hpd_sense_monitor_chk #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 3,
  localparam int LIVE_W = 4 + LANES,
  localparam int INT_W  = 2 + LANES
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              irqOut,
  input logic [LIVE_W-1:0] liveStatus,
  input logic [LIVE_W-1:0] polarityReg,
  input logic [LIVE_W-1:0] maskReg,
  input logic [INT_W-1:0]  intStatus
);

  // R7
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(3)) |=> ((intStatus & $past(intStatus)) == $past(intStatus)));

  // R5
  hpd_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[0]) |-> !$past(maskReg[1]));

  // R5
  lock_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[1]) |-> !$past(maskReg[0]));

  // R3
  hpd_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[0]) |-> $past(liveStatus[1] == polarityReg[1]));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (intStatus != '0));

endmodule

bind hpd_sense_monitor hpd_sense_monitor_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .irqOut     (irqOut),
  .liveStatus (liveStatus),
  .polarityReg(polarityReg),
  .maskReg    (maskReg),
  .intStatus  (intStatus)
);

// File: tb/sim_hpd_sense_monitor.sv
module sim_hpd_sense_monitor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       hotplugRaw = 1'b0;
  logic       phyLockRaw = 1'b0;
  logic [3:0] rxSenseRaw = '0;
  logic       irqOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hpd_sense_monitor u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .hotplugRaw(hotplugRaw),
    .phyLockRaw(phyLockRaw), .rxSenseRaw(rxSenseRaw), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic setIn(input logic h, input logic l, input logic [3:0] s);
    @(negedge clk);
    hotplugRaw = h; phyLockRaw = l; rxSenseRaw = s;
    settle();
  endtask

  task automatic test_reset();
    logic [7:0] v;
    rd(0, v); chk("R1 live", v, 8'h00);
    rd(1, v); chk("R1 polarity", v, 8'h00);
    rd(2, v); chk("R1 mask", v, 8'hF3);
    rd(3, v); chk("R1 events", v, 8'h00);
    rd(4, v); chk("R1 mute", v, 8'h3F);
    chk("R1 irq", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic test_live_layout();
    logic [7:0] v;
    setIn(1'b1, 1'b0, 4'b1010);
    rd(0, v); chk("R2 layout", v, 8'hA2);
    @(negedge clk);
    regAddr = 3'd0; phyLockRaw = 1'b1;
    @(posedge clk); #1 chk("R2 one edge", regRdData, 8'hA2);
    @(posedge clk); #1 chk("R2 two edges", regRdData, 8'hA3);
    setIn(1'b0, 1'b0, 4'b0000);
    // all transitions happened while masked
    rd(3, v); chk("R5 masked after reset", v, 8'h00);
  endtask

  task automatic test_connect();
    logic [7:0] v;
    wr(3, 8'hFF);
    wr(2, 8'h00);
    rd(3, v); chk("R5 unmask while matching", v, 8'h00);
    wr(1, 8'h02);
    rd(3, v); chk("R3 no match no event", v, 8'h00);
    @(negedge clk);
    regAddr = 3'd3; hotplugRaw = 1'b1;
    @(posedge clk); @(posedge clk); #1 chk("R3 not yet", regRdData, 8'h00);
    @(posedge clk); #1 chk("R10 connect event", regRdData, 8'h01);
    wr(3, 8'h01);
    settle();
    rd(3, v); chk("R3 only once", v, 8'h00);
  endtask

  task automatic test_disconnect();
    logic [7:0] v;
    wr(1, 8'h00);
    rd(3, v); chk("R10 no event while connected", v, 8'h00);
    setIn(1'b0, 1'b0, 4'b0000);
    rd(3, v); chk("R10 disconnect event", v, 8'h01);
    wr(3, 8'hFF);
  endtask

  task automatic test_sense_map();
    logic [7:0] v;
    wr(1, 8'hF3);
    rd(3, v); chk("R4 no event", v, 8'h00);
    setIn(1'b0, 1'b1, 4'b0000); rd(3, v); chk("R4 lock bit1", v, 8'h02);
    setIn(1'b0, 1'b1, 4'b0100); rd(3, v); chk("R4 sense2 bit4", v, 8'h12);
    setIn(1'b0, 1'b1, 4'b0101); rd(3, v); chk("R4 sense0 bit2", v, 8'h16);
    setIn(1'b0, 1'b1, 4'b1101); rd(3, v); chk("R4 sense3 bit5", v, 8'h36);
    setIn(1'b0, 1'b1, 4'b1111); rd(3, v); chk("R4 sense1 bit3", v, 8'h3E);
    setIn(1'b1, 1'b1, 4'b1111); rd(3, v); chk("R4 hotplug bit0", v, 8'h3F);
    wr(3, 8'hFF);
    setIn(1'b0, 1'b0, 4'b0000);
    rd(3, v); chk("R3 leaving level no event", v, 8'h00);
    wr(1, 8'h00);
    rd(3, v); chk("R6 polarity to matching", v, 8'h3F);
    wr(3, 8'hFF);
    settle();
    rd(3, v); chk("R6 single event", v, 8'h00);
  endtask

  task automatic test_mask();
    logic [7:0] v;
    wr(2, 8'h02);
    wr(1, 8'h02);
    setIn(1'b1, 1'b0, 4'b0000);
    rd(3, v); chk("R5 masked hotplug", v, 8'h00);
    wr(2, 8'h00);
    settle();
    rd(3, v); chk("R5 unmask when matching", v, 8'h00);
    setIn(1'b0, 1'b0, 4'b0000);
    wr(1, 8'h00);
    rd(3, v); chk("R6 unmasked polarity match", v, 8'h01);
    wr(3, 8'hFF);
  endtask

  task automatic test_w1c();
    logic [7:0] v;
    wr(1, 8'hF3);
    wr(1, 8'h00);
    rd(3, v); chk("R7 setup", v, 8'h3F);
    wr(3, 8'h05); rd(3, v); chk("R7 partial clear", v, 8'h3A);
    wr(3, 8'h00); rd(3, v); chk("R7 zero write", v, 8'h3A);
    wr(3, 8'hFF); rd(3, v); chk("R7 full clear", v, 8'h00);
  endtask

  task automatic test_set_wins();
    logic [7:0] v;
    wr(1, 8'h02);
    @(negedge clk);
    hotplugRaw = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    regAddr = 3'd3; regWrData = 8'h01; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 chk("R7 set beats clear", regRdData, 8'h01);
    wr(3, 8'hFF);
    wr(1, 8'h00);
    setIn(1'b0, 1'b0, 4'b0000);
    wr(3, 8'hFF);
    rd(3, v); chk("R7 cleaned", v, 8'h00);
  endtask

  task automatic test_mute();
    logic [7:0] v;
    wr(1, 8'hF3);
    wr(1, 8'h00);
    #1 chk("R8 all muted", {7'd0, irqOut}, 8'h00);
    wr(4, 8'h3E); #1 chk("R8 unmute hotplug", {7'd0, irqOut}, 8'h01);
    wr(4, 8'h3F); #1 chk("R8 remute", {7'd0, irqOut}, 8'h00);
    rd(3, v); chk("R8 events kept", v, 8'h3F);
    wr(3, 8'h3E);
    wr(4, 8'h00); #1 chk("R8 one source", {7'd0, irqOut}, 8'h01);
    wr(3, 8'h01); #1 chk("R8 cleared", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic test_addr_map();
    logic [7:0] v;
    wr(0, 8'hFF); rd(0, v); chk("R9 live read only", v, 8'h00);
    rd(5, v); chk("R9 addr5", v, 8'h00);
    rd(6, v); chk("R9 addr6", v, 8'h00);
    rd(7, v); chk("R9 addr7", v, 8'h00);
    wr(1, 8'hFF); rd(1, v); chk("R9 polarity reserved", v, 8'hF3);
    wr(2, 8'hFF); rd(2, v); chk("R9 mask reserved", v, 8'hF3);
    wr(4, 8'hFF); rd(4, v); chk("R9 mute reserved", v, 8'h3F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0x00 expected 0x01");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_live_layout();
    test_connect();
    test_disconnect();
    test_sense_map();
    test_mask();
    test_w1c();
    test_set_wins();
    test_mute();
    test_addr_map();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule